// File: doc/BRIEF.md
# Shifter and Rotated-Immediate Operand Unit

This block builds the second operand for the ALU of a 32-bit processor. In register form it takes a register value and applies one of four shift kinds. The shift amount comes either from a 5-bit instruction field or from the low byte of a second register. In immediate form it takes an 8-bit constant and rotates it right by twice a 4-bit rotate field. This reaches many 32-bit constants that do not fit in eight bits.

Alongside the operand, the block produces a shifter carry that the flag logic uses. A register-sourced amount can be as large as 255, so the block defines the result and the carry for amounts of 32 and above. The datapath is combinational. A parameter adds one output register stage for timing closure.

Top module: `shift_operand_unit`

## Requirements
- R1: When `use_imm_i` is 1, `operand_o` equals `imm_val_i` zero-extended to 32 bits and rotated right by 2*`imm_rot_i` positions (0 to 30).
- R2: In immediate form, `carry_o` equals `operand_o[31]` when `imm_rot_i` is nonzero, and equals `carry_i` when `imm_rot_i` is 0.
- R3: In register form, `shift_kind_i` selects the operation: 2'b00 logical left, 2'b01 logical right, 2'b10 arithmetic right, 2'b11 rotate right. For an amount n from 1 to 31, the carry is the last bit shifted out. That is bit 32-n for a left shift, bit n-1 for the right shifts, and result bit 31 for a rotate.
- R4: When `amt_from_reg_i` is 0, the amount is `amt_field_i` (5 bits) and `amt_reg_i` is ignored. When it is 1, the amount is `amt_reg_i` (8 bits) and `amt_field_i` is ignored.
- R5: An amount of 0, from either source and for any shift kind, passes `reg_val_i` unchanged and passes `carry_i` to `carry_o`.
- R6: For an amount of exactly 32:
  - a logical left shift gives 0 with carry equal to input bit 0;
  - a logical right shift gives 0 with carry equal to input bit 31;
  - an arithmetic right shift gives 32 copies of bit 31 with carry equal to bit 31.
- R7: For an amount above 32, both logical shifts give 0 with carry 0. An arithmetic right shift gives 32 copies of bit 31 with carry equal to bit 31.
- R8: A rotate uses the amount modulo 32. A nonzero amount that is a multiple of 32 leaves the value unchanged and sets the carry to bit 31.
- R9: With `OUT_REG`=1, `operand_o` and `carry_o` change only at a rising clock edge and show the result of the inputs present at that edge. Reset drives both outputs to 0. With `OUT_REG`=0, the outputs are combinational.
- R10: In immediate form, `reg_val_i`, `shift_kind_i`, `amt_from_reg_i`, `amt_field_i` and `amt_reg_i` have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output stage |
| rst_ni | input | 1 | Asynchronous active-low reset |
| use_imm_i | input | 1 | 1 selects immediate form, 0 selects register form |
| imm_val_i | input | 8 | Packed immediate constant |
| imm_rot_i | input | 4 | Rotate field; the rotate is twice this value |
| reg_val_i | input | 32 | Register value to be shifted |
| shift_kind_i | input | 2 | Shift kind: 00 LSL, 01 LSR, 10 ASR, 11 ROR |
| amt_from_reg_i | input | 1 | 1 takes the amount from `amt_reg_i` |
| amt_field_i | input | 5 | Shift amount from the instruction field |
| amt_reg_i | input | 8 | Shift amount from the low byte of a second register |
| carry_i | input | 1 | Incoming carry flag |
| operand_o | output | 32 | Second ALU operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The bench builds the block with `OUT_REG`=1 and keeps the 32-bit width, 8-bit immediate, 4-bit rotate field and 8-bit register amount. This lets one instance exercise the reset value of the output stage, its one-edge latency and every shifter corner. With an 8-bit register amount the bench can reach the boundaries at 32, 33, 64 and 255. Those are the cases where logical shifts saturate, the arithmetic shift fills with the sign bit and a rotate wraps modulo 32. The bench also sweeps all sixteen rotate values of the immediate form with both carry-in values.

// File: rtl/sou_pkg.sv
package sou_pkg;
  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/sou_imm_rotator.sv
module sou_imm_rotator #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [ROT_W-1:0]  rot_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o
);
  localparam int RW = ROT_W + 2;

  logic [DATA_W-1:0] ext;
  logic [ROT_W:0]    r;
  logic [RW-1:0]     back;

  assign ext  = {{(DATA_W-IMM_W){1'b0}}, imm_i};
  assign r    = {rot_i, 1'b0};
  assign back = RW'(DATA_W) - {1'b0, r};

  always_comb begin
    if (rot_i == '0) res_o = ext;
    else             res_o = (ext >> r) | (ext << back);
  end

  assign carry_o = (rot_i != '0) ? res_o[DATA_W-1] : carry_i;
endmodule

// File: rtl/sou_barrel.sv
module sou_barrel
  import sou_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  shift_kind_e       kind_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o
);
  localparam int LOG = $clog2(DATA_W);

  logic [DATA_W-1:0] data_rev, body, body_rev;
  logic [DATA_W:0]   sh_stage [LOG+1];
  logic [DATA_W-1:0] ro_stage [LOG+1];
  logic              fill, big, exact;

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign data_rev[i] = data_i[DATA_W-1-i];
    assign body_rev[i] = body[DATA_W-1-i];
  end

  assign fill = (kind_i == SK_ASR) ? data_i[DATA_W-1] : 1'b0;
  // bit 0 of the shift word tracks the last bit shifted out
  assign sh_stage[0] = (kind_i == SK_LSL) ? {data_rev, carry_i} : {data_i, carry_i};
  assign ro_stage[0] = data_i;

  for (genvar s = 0; s < LOG; s++) begin : g_stage
    localparam int SH = 1 << s;
    assign sh_stage[s+1] = amt_i[s] ? {{SH{fill}}, sh_stage[s][DATA_W:SH]} : sh_stage[s];
    assign ro_stage[s+1] = amt_i[s] ? {ro_stage[s][SH-1:0], ro_stage[s][DATA_W-1:SH]}
                                    : ro_stage[s];
  end

  if (AMT_W > LOG) begin : g_big
    assign big   = |amt_i[AMT_W-1:LOG];
    assign exact = (amt_i == AMT_W'(DATA_W));
  end else begin : g_nobig
    assign big   = 1'b0;
    assign exact = 1'b0;
  end

  assign body = sh_stage[LOG][DATA_W:1];

  always_comb begin
    res_o   = data_i;
    carry_o = carry_i;
    if (kind_i == SK_ROR) begin
      res_o = ro_stage[LOG];
      if (amt_i == '0)                 carry_o = carry_i;
      else if (amt_i[LOG-1:0] == '0)   carry_o = data_i[DATA_W-1];
      else                             carry_o = ro_stage[LOG][DATA_W-1];
    end else if (big) begin
      res_o = {DATA_W{fill}};
      if (kind_i == SK_ASR)      carry_o = data_i[DATA_W-1];
      else if (!exact)           carry_o = 1'b0;
      else if (kind_i == SK_LSL) carry_o = data_i[0];
      else                       carry_o = data_i[DATA_W-1];
    end else begin
      res_o   = (kind_i == SK_LSL) ? body_rev : body;
      carry_o = sh_stage[LOG][0];
    end
  end
endmodule

// File: rtl/sou_out_stage.sv
module sou_out_stage #(
  parameter int DATA_W  = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] res_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o
);
  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        res_o   <= '0;
        carry_o <= 1'b0;
      end else begin
        res_o   <= res_i;
        carry_o <= carry_i;
      end
    end
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign res_o      = res_i;
    assign carry_o    = carry_i;
  end
endmodule

// File: rtl/shift_operand_unit.sv
module shift_operand_unit
  import sou_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IMM_W     = 8,
  parameter int ROT_W     = 4,
  parameter int AMT_W     = 5,
  parameter int REG_AMT_W = 8,
  parameter bit OUT_REG   = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 use_imm_i,
  input  logic [IMM_W-1:0]     imm_val_i,
  input  logic [ROT_W-1:0]     imm_rot_i,
  input  logic [DATA_W-1:0]    reg_val_i,
  input  logic [1:0]           shift_kind_i,
  input  logic                 amt_from_reg_i,
  input  logic [AMT_W-1:0]     amt_field_i,
  input  logic [REG_AMT_W-1:0] amt_reg_i,
  input  logic                 carry_i,
  output logic [DATA_W-1:0]    operand_o,
  output logic                 carry_o
);
  logic [REG_AMT_W-1:0] amt_sel;
  logic [DATA_W-1:0]    imm_res, sh_res, mux_res;
  logic                 imm_c, sh_c, mux_c;
  shift_kind_e          kind;

  assign kind    = shift_kind_e'(shift_kind_i);
  assign amt_sel = amt_from_reg_i ? amt_reg_i
                                  : {{(REG_AMT_W-AMT_W){1'b0}}, amt_field_i};

  sou_imm_rotator #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_imm (
    .imm_i   (imm_val_i),
    .rot_i   (imm_rot_i),
    .carry_i (carry_i),
    .res_o   (imm_res),
    .carry_o (imm_c)
  );

  sou_barrel #(.DATA_W(DATA_W), .AMT_W(REG_AMT_W)) u_barrel (
    .data_i  (reg_val_i),
    .amt_i   (amt_sel),
    .kind_i  (kind),
    .carry_i (carry_i),
    .res_o   (sh_res),
    .carry_o (sh_c)
  );

  assign mux_res = use_imm_i ? imm_res : sh_res;
  assign mux_c   = use_imm_i ? imm_c   : sh_c;

  sou_out_stage #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .res_i   (mux_res),
    .carry_i (mux_c),
    .res_o   (operand_o),
    .carry_o (carry_o)
  );
endmodule

// File: rtl/sou_checker.sv
module sou_checker #(
  parameter int DATA_W    = 32,
  parameter int IMM_W     = 8,
  parameter int ROT_W     = 4,
  parameter int AMT_W     = 5,
  parameter int REG_AMT_W = 8,
  parameter bit OUT_REG   = 1'b1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 use_imm_i,
  input logic [IMM_W-1:0]     imm_val_i,
  input logic [ROT_W-1:0]     imm_rot_i,
  input logic [DATA_W-1:0]    reg_val_i,
  input logic [1:0]           shift_kind_i,
  input logic                 amt_from_reg_i,
  input logic [AMT_W-1:0]     amt_field_i,
  input logic [REG_AMT_W-1:0] amt_reg_i,
  input logic                 carry_i,
  input logic [DATA_W-1:0]    operand_o,
  input logic                 carry_o
);
  logic                 valid, d_imm, d_c;
  logic [IMM_W-1:0]     d_val;
  logic [ROT_W-1:0]     d_rot;
  logic [DATA_W-1:0]    d_x;
  logic [1:0]           d_kind;
  logic [REG_AMT_W-1:0] d_amt;
  logic [REG_AMT_W-1:0] amt_now;

  assign amt_now = amt_from_reg_i ? amt_reg_i : {{(REG_AMT_W-AMT_W){1'b0}}, amt_field_i};

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid <= 1'b0; d_imm <= 1'b0; d_c <= 1'b0; d_val <= '0;
        d_rot <= '0; d_x <= '0; d_kind <= '0; d_amt <= '0;
      end else begin
        valid <= 1'b1; d_imm <= use_imm_i; d_c <= carry_i; d_val <= imm_val_i;
        d_rot <= imm_rot_i; d_x <= reg_val_i; d_kind <= shift_kind_i; d_amt <= amt_now;
      end
    end
  end else begin : g_comb
    assign valid = 1'b1; assign d_imm = use_imm_i; assign d_c = carry_i;
    assign d_val = imm_val_i; assign d_rot = imm_rot_i; assign d_x = reg_val_i;
    assign d_kind = shift_kind_i; assign d_amt = amt_now;
  end

  p_imm_carry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid && d_imm && d_rot != '0 |-> carry_o == operand_o[DATA_W-1]);

  p_imm_norot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid && d_imm && d_rot == '0 |->
      operand_o == {{(DATA_W-IMM_W){1'b0}}, d_val} && carry_o == d_c);

  p_zero_amt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid && !d_imm && d_amt == '0 |-> operand_o == d_x && carry_o == d_c);

  p_logic_big_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid && !d_imm && d_kind[1] == 1'b0 && d_amt > REG_AMT_W'(DATA_W) |->
      operand_o == '0 && !carry_o);

  p_asr_fill_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid && !d_imm && d_kind == 2'b10 && d_amt >= REG_AMT_W'(DATA_W) |->
      operand_o == {DATA_W{d_x[DATA_W-1]}} && carry_o == d_x[DATA_W-1]);

  p_ror_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid && !d_imm && d_kind == 2'b11 && d_amt != '0 &&
      d_amt[$clog2(DATA_W)-1:0] == '0 |-> operand_o == d_x && carry_o == d_x[DATA_W-1]);

  p_reset_out_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    OUT_REG && !valid |-> operand_o == '0 && !carry_o);
endmodule

bind shift_operand_unit sou_checker #(
  .DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W),
  .AMT_W(AMT_W), .REG_AMT_W(REG_AMT_W), .OUT_REG(OUT_REG)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .use_imm_i(use_imm_i), .imm_val_i(imm_val_i),
  .imm_rot_i(imm_rot_i), .reg_val_i(reg_val_i), .shift_kind_i(shift_kind_i),
  .amt_from_reg_i(amt_from_reg_i), .amt_field_i(amt_field_i), .amt_reg_i(amt_reg_i),
  .carry_i(carry_i), .operand_o(operand_o), .carry_o(carry_o)
);

// File: tb/shift_operand_unit_tb.sv
module shift_operand_unit_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        use_imm = 1'b0;
  logic [7:0]  imm_val = '0;
  logic [3:0]  imm_rot = '0;
  logic [31:0] reg_val = '0;
  logic [1:0]  kind = '0;
  logic        from_reg = 1'b0;
  logic [4:0]  amt_field = '0;
  logic [7:0]  amt_reg = '0;
  logic        cin = 1'b0;
  logic [31:0] operand;
  logic        cout;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  shift_operand_unit #(.OUT_REG(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .use_imm_i(use_imm), .imm_val_i(imm_val),
    .imm_rot_i(imm_rot), .reg_val_i(reg_val), .shift_kind_i(kind),
    .amt_from_reg_i(from_reg), .amt_field_i(amt_field), .amt_reg_i(amt_reg),
    .carry_i(cin), .operand_o(operand), .carry_o(cout)
  );

  function automatic logic [32:0] ref_shift(input logic [31:0] x, input logic [1:0] k,
                                            input int n, input logic c);
    logic [63:0] full;
    logic signed [63:0] sfull;
    logic [31:0] r;
    int m;
    if (n == 0) return {c, x};
    case (k)
      2'b00: begin
        if (n > 32) return 33'd0;
        full = {32'd0, x} << n;
        return {full[32], full[31:0]};
      end
      2'b01: begin
        if (n > 32) return 33'd0;
        full = {x, 32'd0} >> n;
        return {full[31], full[63:32]};
      end
      2'b10: begin
        if (n >= 32) return {x[31], {32{x[31]}}};
        sfull = {x, 32'd0};
        sfull = sfull >>> n;
        return {sfull[31], sfull[63:32]};
      end
      default: begin
        m = n % 32;
        if (m == 0) return {x[31], x};
        r = (x >> m) | (x << (32 - m));
        return {r[31], r};
      end
    endcase
  endfunction

  function automatic logic [32:0] ref_imm(input logic [7:0] v, input logic [3:0] rot,
                                          input logic c);
    logic [31:0] e, r;
    int n;
    e = {24'd0, v};
    n = 2 * int'(rot);
    r = (n == 0) ? e : ((e >> n) | (e << (32 - n)));
    return {(rot != 0) ? r[31] : c, r};
  endfunction

  task automatic check(input string tag, input logic [32:0] exp);
    checks++;
    if ({cout, operand} !== exp) begin
      errors++;
      $display("FAIL %s: got carry=%0b operand=%h, expected carry=%0b operand=%h",
               tag, cout, operand, exp[32], exp[31:0]);
    end
  endtask

  task automatic apply;
    @(posedge clk);
    #1;
  endtask

  task automatic drive_reg(input logic [31:0] x, input logic [1:0] k, input logic src,
                           input logic [4:0] f, input logic [7:0] ra, input logic c);
    @(negedge clk);
    use_imm = 1'b0; reg_val = x; kind = k; from_reg = src;
    amt_field = f; amt_reg = ra; cin = c;
    apply();
  endtask

  task automatic drive_imm(input logic [7:0] v, input logic [3:0] rot, input logic c);
    @(negedge clk);
    use_imm = 1'b1; imm_val = v; imm_rot = rot; cin = c;
    apply();
  endtask

  task automatic t_reset;
    #1;
    check("R9 reset value", 33'd0);
    drive_reg(32'hFFFF_FFFF, 2'b00, 1'b0, 5'd0, 8'd0, 1'b1);
    check("R9 reset still held", 33'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    apply();
    check("R9 first edge after reset", {1'b1, 32'hFFFF_FFFF});
  endtask

  task automatic t_latency;
    drive_reg(32'h0000_00F0, 2'b01, 1'b0, 5'd4, 8'd0, 1'b0);
    check("R9 registered result", ref_shift(32'h0000_00F0, 2'b01, 4, 1'b0));
    @(negedge clk);
    reg_val = 32'h1234_5678; amt_field = 5'd8;
    #2;
    check("R9 no change between edges", ref_shift(32'h0000_00F0, 2'b01, 4, 1'b0));
    apply();
    check("R9 new result after edge", ref_shift(32'h1234_5678, 2'b01, 8, 1'b0));
  endtask

  task automatic t_imm;
    for (int r = 0; r < 16; r++) begin
      drive_imm(8'hA5, 4'(r), r[0]);
      check($sformatf("R1 R2 imm rot=%0d", r), ref_imm(8'hA5, 4'(r), r[0]));
    end
    drive_imm(8'hFF, 4'd4, 1'b0);
    check("R1 imm FF rot 8", {1'b1, 32'hFF00_0000});
    drive_imm(8'h01, 4'd1, 1'b0);
    check("R2 imm carry from bit31", {1'b0, 32'h4000_0000});
    drive_imm(8'h3C, 4'd0, 1'b1);
    check("R2 imm no rotate passes carry", {1'b1, 32'h0000_003C});
  endtask

  task automatic t_imm_ignores;
    @(negedge clk);
    use_imm = 1'b1; imm_val = 8'h81; imm_rot = 4'd3; cin = 1'b0;
    reg_val = 32'hDEAD_BEEF; kind = 2'b10; from_reg = 1'b1; amt_reg = 8'd200;
    apply();
    check("R10 imm with shift inputs A", ref_imm(8'h81, 4'd3, 1'b0));
    @(negedge clk);
    reg_val = 32'h0; kind = 2'b00; from_reg = 1'b0; amt_field = 5'd17; amt_reg = 8'd1;
    apply();
    check("R10 imm with shift inputs B", ref_imm(8'h81, 4'd3, 1'b0));
  endtask

  task automatic t_field;
    logic [31:0] pats [3] = '{32'h8000_0001, 32'hC3A5_5A3C, 32'h7FFF_FFFE};
    int amts [3] = '{1, 7, 31};
    for (int p = 0; p < 3; p++)
      for (int k = 0; k < 4; k++)
        for (int a = 0; a < 3; a++) begin
          drive_reg(pats[p], 2'(k), 1'b0, 5'(amts[a]), 8'd0, 1'b0);
          check($sformatf("R3 kind=%0d amt=%0d pat=%0d", k, amts[a], p),
                ref_shift(pats[p], 2'(k), amts[a], 1'b0));
        end
  endtask

  task automatic t_source;
    drive_reg(32'h0000_0001, 2'b00, 1'b1, 5'd3, 8'd5, 1'b0);
    check("R4 register amount used", {1'b0, 32'h0000_0020});
    drive_reg(32'h0000_0001, 2'b00, 1'b0, 5'd3, 8'd5, 1'b0);
    check("R4 field amount used", {1'b0, 32'h0000_0008});
    drive_reg(32'h0000_0001, 2'b00, 1'b0, 5'd3, 8'd255, 1'b0);
    check("R4 field ignores reg byte", {1'b0, 32'h0000_0008});
  endtask

  task automatic t_zero;
    for (int k = 0; k < 4; k++) begin
      drive_reg(32'h9ABC_DEF1, 2'(k), 1'b1, 5'd9, 8'd0, 1'b1);
      check($sformatf("R5 reg zero kind=%0d", k), {1'b1, 32'h9ABC_DEF1});
      drive_reg(32'h9ABC_DEF1, 2'(k), 1'b0, 5'd0, 8'd40, 1'b0);
      check($sformatf("R5 field zero kind=%0d", k), {1'b0, 32'h9ABC_DEF1});
    end
  endtask

  task automatic t_large;
    drive_reg(32'h0000_0001, 2'b00, 1'b1, 5'd0, 8'd32, 1'b0);
    check("R6 LSL 32", {1'b1, 32'h0});
    drive_reg(32'h8000_0000, 2'b01, 1'b1, 5'd0, 8'd32, 1'b0);
    check("R6 LSR 32", {1'b1, 32'h0});
    drive_reg(32'h8000_1234, 2'b10, 1'b1, 5'd0, 8'd32, 1'b0);
    check("R6 ASR 32 negative", {1'b1, 32'hFFFF_FFFF});
    drive_reg(32'h7000_1234, 2'b10, 1'b1, 5'd0, 8'd32, 1'b1);
    check("R6 ASR 32 positive", {1'b0, 32'h0});
    drive_reg(32'hFFFF_FFFF, 2'b00, 1'b1, 5'd0, 8'd33, 1'b1);
    check("R7 LSL 33", 33'd0);
    drive_reg(32'hFFFF_FFFF, 2'b01, 1'b1, 5'd0, 8'd100, 1'b1);
    check("R7 LSR 100", 33'd0);
    drive_reg(32'h8000_0000, 2'b10, 1'b1, 5'd0, 8'd255, 1'b0);
    check("R7 ASR 255", {1'b1, 32'hFFFF_FFFF});
    drive_reg(32'hFFFF_FFFF, 2'b01, 1'b1, 5'd0, 8'd64, 1'b1);
    check("R7 LSR 64", 33'd0);
  endtask

  task automatic t_ror;
    drive_reg(32'h8000_0001, 2'b11, 1'b1, 5'd0, 8'd32, 1'b0);
    check("R8 ROR 32", {1'b1, 32'h8000_0001});
    drive_reg(32'h0000_0003, 2'b11, 1'b1, 5'd0, 8'd64, 1'b1);
    check("R8 ROR 64", {1'b0, 32'h0000_0003});
    drive_reg(32'h0000_0020, 2'b11, 1'b1, 5'd0, 8'd37, 1'b0);
    check("R8 ROR 37", ref_shift(32'h0000_0020, 2'b11, 37, 1'b0));
    drive_reg(32'h1234_5678, 2'b11, 1'b1, 5'd0, 8'd255, 1'b0);
    check("R8 ROR 255", ref_shift(32'h1234_5678, 2'b11, 255, 1'b0));
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_latency();
    t_imm();
    t_imm_ignores();
    t_field();
    t_source();
    t_zero();
    t_large();
    t_ror();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule